// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with In-Place Parity

This block serialises words onto a single idle-high line. A producer presents a 9-bit word with a one-cycle write strobe. The word waits in a one-entry holding register until the shifter is free. It is then framed as a low start bit, a payload sent least significant bit first, and a high stop bit. Two flags report progress: `tx_empty` says the holding register can take another word, and `tx_done` says the line has gone quiet with nothing left to send.

A frame-length select chooses 8 or 9 payload bits. With parity enabled, the payload length does not change. The topmost payload bit of the written word is dropped, and a parity bit goes in its place. That parity bit is computed over the remaining low bits, so a frame is the same length with parity on or off. Bit timing comes from an external oversampling enable. Each bit lasts a fixed number of those enables.

The frame-length and parity controls are read when a word moves into the shifter. Changing them while a frame is on the line has no effect on that frame.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1 and `tx_done` is 1.
- R2: A `wr_stb` pulse while `tx_empty` is 1 stores `wr_data`. In the next cycle `tx_empty` and `tx_done` are both 0.
- R3: A `wr_stb` pulse while `tx_empty` is 0 is ignored. The waiting word is kept and the discarded word is never sent.
- R4: When the shifter is idle, a stored word enters it one cycle after it is written. In that cycle `tx_empty` returns to 1 and `txd` drops to 0 (start bit).
- R5: A frame is one start bit of 0, then the payload least significant bit first, then one stop bit of 1. `len9`=0 gives 8 payload bits and `len9`=1 gives 9.
- R6: Each bit lasts exactly 16 cycles in which `os_tick` is 1. `txd` does not change in a cycle where `os_tick` is 0 during a frame.
- R7: With `par_en`=0, the payload is bits 7..0 (`len9`=0) or bits 8..0 (`len9`=1) of the written word, unchanged.
- R8: With `par_en`=1, payload bit 7 (`len9`=0) or bit 8 (`len9`=1) is replaced by a parity bit. The parity bit is computed over the low 7 or 8 bits. With `par_odd`=0 the ones in those bits plus the parity bit form an even count; with `par_odd`=1 they form an odd count. For example, low byte 00110101 with `len9`=1 gives parity 0 (even) or 1 (odd).
- R9: `len9`, `par_en` and `par_odd` are sampled when a word enters the shifter. Later changes do not alter the frame in progress.
- R10: If no word is waiting when a stop bit ends, `tx_done` is 1 in the next cycle and `txd` stays 1. If a word is waiting, its start bit follows immediately with no idle bit and `tx_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable; 16 per bit |
| len9 | input | 1 | Payload length select: 0 = 8 bits, 1 = 9 bits |
| par_en | input | 1 | Parity substitution enable |
| par_odd | input | 1 | Parity sense: 0 = even, 1 = odd |
| wr_stb | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 9 | Word to transmit |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | Holding register can accept a word |
| tx_done | output | 1 | Line idle with nothing pending |

## Verification
Directed frames use the 00110101 pattern in both frame lengths with even and odd parity. Matching those against the plain-payload case separates a parity bit from the raw MSB and shows which bit range the parity is computed over. A back-to-back sequence writes one word during a frame and then a third word while the holding register is full. This tells apart gap-free chaining, a silently dropped write, and a spurious completion flag. Random words, random configurations and random `os_tick` spacing check the tick-based bit timing. In those random frames the controls are changed in mid-frame, which shows that the configuration is latched when the word enters the shifter.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int WORD_W  = 9;
    localparam int FRAME_W = WORD_W + 2;

    typedef struct packed {
        logic len9;
        logic par_en;
        logic par_odd;
    } sertx_cfg_t;
endpackage

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  sertx_cfg_t        cfg,
    output logic [WORD_W-1:0] payload
);
    logic par7, par8;

    always_comb begin
        par7 = (^word[WORD_W-3:0]) ^ cfg.par_odd;
        par8 = (^word[WORD_W-2:0]) ^ cfg.par_odd;
        if (cfg.len9) begin
            payload = {(cfg.par_en ? par8 : word[WORD_W-1]), word[WORD_W-2:0]};
        end else begin
            payload = {1'b1, (cfg.par_en ? par7 : word[WORD_W-2]), word[WORD_W-3:0]};
        end
    end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic              accept,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] word;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d      = q;
        accept = wr_stb && !q.full;
        if (take) d.full = 1'b0;
        if (accept) begin
            d.full = 1'b1;
            d.word = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full = q.full;
    assign word = q.word;

    p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && q.full) |=> $stable(q.word));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              have_word,
    input  logic              accept,
    input  logic              len9,
    input  logic [WORD_W-1:0] payload,
    output logic              take,
    output logic              txd,
    output logic              done
);
    localparam int TICK_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int BIT_W  = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [FRAME_W-1:0] sh;
        logic [BIT_W-1:0]   bitn;
        logic [BIT_W-1:0]   last;
        logic [TICK_W-1:0]  tick;
    } shift_t;

    shift_t q, d;
    logic   bit_end, frame_end;

    always_comb begin
        d         = q;
        take      = 1'b0;
        bit_end   = q.busy && os_tick && (q.tick == TICK_W'(OSR - 1));
        frame_end = bit_end && (q.bitn == q.last);
        if (q.busy && os_tick) d.tick = q.tick + 1'b1;
        if (bit_end) begin
            d.tick = '0;
            d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
            d.bitn = q.bitn + 1'b1;
        end
        if (frame_end) begin
            d.busy = 1'b0;
            d.done = 1'b1;
        end
        if (have_word && (!q.busy || frame_end)) begin
            take   = 1'b1;
            d.busy = 1'b1;
            d.done = 1'b0;
            d.sh   = {1'b1, payload, 1'b0};
            d.bitn = '0;
            d.tick = '0;
            d.last = len9 ? BIT_W'(FRAME_W - 1) : BIT_W'(FRAME_W - 2);
        end
        if (accept) d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.done <= 1'b1;
            q.sh   <= '1;
        end else begin
            q <= d;
        end
    end

    assign txd  = q.sh[0];
    assign done = q.done;

    p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !txd);
    p_hold_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !os_tick) |=> $stable(txd));
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              len9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_done
);
    sertx_cfg_t        cfg;
    logic              full, accept, take;
    logic [WORD_W-1:0] word, payload;

    assign cfg = '{len9: len9, par_en: par_en, par_odd: par_odd};

    sertx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .take(take), .full(full), .accept(accept), .word(word)
    );

    sertx_frame u_frame (.word(word), .cfg(cfg), .payload(payload));

    sertx_shift #(.OSR(OSR)) u_shift (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .have_word(full),
        .accept(accept), .len9(len9), .payload(payload), .take(take),
        .txd(txd), .done(tx_done)
    );

    assign tx_empty = !full;

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_empty) |=> (!tx_empty && !tx_done));
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (txd && tx_empty));
endmodule

// File: tb/sertx_core_test.sv
module sertx_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;

    logic       clk = 0, rst_n = 0, os_tick = 0;
    logic       len9 = 0, par_en = 0, par_odd = 0, wr_stb = 0;
    logic [8:0] wr_data = '0;
    logic       txd, tx_empty, tx_done;

    int  n_chk = 0, n_bad = 0, os_per = 1, tick_total = 0;
    bit  ended = 0;

    sertx_core #(.OSR(OSR)) uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .len9(len9),
        .par_en(par_en), .par_odd(par_odd), .wr_stb(wr_stb), .wr_data(wr_data),
        .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            if (os_tick) tick_total++;
            #1;
            os_tick = (ph == 0);
            ph = (ph + 1 >= os_per) ? 0 : ph + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_payload(input logic [8:0] w, input bit l9,
                                               input bit pe, input bit od);
        int ones = 0;
        logic p;
        logic [8:0] r = w;
        for (int i = 0; i < (l9 ? 8 : 7); i++) ones += w[i];
        p = ((ones % 2) == 1) ^ od;
        if (l9) r[8] = pe ? p : w[8];
        else begin
            r[8] = 1'b0;
            r[7] = pe ? p : w[7];
        end
        return r;
    endfunction

    task automatic write(input logic [8:0] w, input bit expect_ok);
        @(negedge clk);
        wr_stb = 1; wr_data = w;
        @(negedge clk);
        wr_stb = 0;
        if (expect_ok)
            check(!tx_empty && !tx_done, "R2", {tx_empty, tx_done}, 0);
    endtask

    task automatic recv(input bit l9, output logic [8:0] got);
        int base;
        int nb = l9 ? 9 : 8;
        got = '0;
        while (txd !== 1'b0) @(negedge clk);
        check(tx_empty === 1'b1, "R4", tx_empty, 1);
        base = tick_total;
        while (tick_total < base + OSR/2) @(negedge clk);
        check(txd === 1'b0, "R5 start", txd, 0);
        for (int i = 1; i <= nb; i++) begin
            while (tick_total < base + OSR*i + OSR/2) @(negedge clk);
            got[i-1] = txd;
        end
        while (tick_total < base + OSR*(nb+1) + OSR/2) @(negedge clk);
        check(txd === 1'b1, "R5 stop", txd, 1);
        while (tick_total < base + OSR*(nb+2)) @(negedge clk);
    endtask

    task automatic frame_check(input logic [8:0] got, input logic [8:0] w,
                               input bit l9, input bit pe, input bit od, input string req);
        logic [8:0] e = exp_payload(w, l9, pe, od);
        logic [8:0] m = l9 ? 9'h1FF : 9'h0FF;
        check((got & m) === (e & m), req, got & m, e & m);
    endtask

    task automatic one_frame(input logic [8:0] w, input bit l9, input bit pe,
                             input bit od, input string req);
        logic [8:0] got;
        len9 = l9; par_en = pe; par_odd = od;
        write(w, 1);
        recv(l9, got);
        frame_check(got, w, l9, pe, od, req);
        check(tx_done === 1'b1 && txd === 1'b1, "R10 done", {tx_done, txd}, 3);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [8:0] ga, gb, wa, wb, wc;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        check(txd === 1 && tx_empty === 1 && tx_done === 1, "R1",
              {txd, tx_empty, tx_done}, 7);
        rst_n = 1;
        @(negedge clk);

        // R8 worked example, both senses, 9-bit payload
        one_frame(9'h035, 1, 1, 0, "R8 even 9b");
        one_frame(9'h035, 1, 1, 1, "R8 odd 9b");
        // R8 over 7 low bits, 8-bit payload
        one_frame(9'h0B5, 0, 1, 0, "R8 even 8b");
        one_frame(9'h0B5, 0, 1, 1, "R8 odd 8b");
        // R7 plain payload
        one_frame(9'h1A5, 1, 0, 0, "R7 9b");
        one_frame(9'h1A5, 0, 0, 1, "R7 8b");

        // R6 sparse ticks
        os_per = 3;
        one_frame(9'h0C3, 1, 0, 0, "R6 slow ticks");
        os_per = 1;

        // R10 chaining and R3 dropped write
        wa = 9'h155; wb = 9'h0AA; wc = 9'h1FF;
        len9 = 1; par_en = 0; par_odd = 0;
        write(wa, 1);
        fork
            recv(1, ga);
            begin
                write(wb, 1);
                write(wc, 0);
                check(tx_empty === 1'b0, "R3 still full", tx_empty, 0);
            end
        join
        frame_check(ga, wa, 1, 0, 0, "R5 first of pair");
        check(txd === 1'b0 && tx_done === 1'b0, "R10 chained", {txd, tx_done}, 0);
        recv(1, gb);
        frame_check(gb, wb, 1, 0, 0, "R3 kept word");
        check(tx_done === 1'b1, "R10 done after pair", tx_done, 1);
        repeat (60) @(negedge clk);
        check(txd === 1'b1 && tx_done === 1'b1, "R3 no extra frame", {txd, tx_done}, 3);

        // Random frames; controls scrambled mid-frame for R9
        for (int n = 0; n < 16; n++) begin
            logic [8:0] w, g;
            bit l9, pe, od;
            w = 9'($urandom); l9 = 1'($urandom); pe = 1'($urandom); od = 1'($urandom);
            os_per = 1 + ($urandom % 3);
            len9 = l9; par_en = pe; par_odd = od;
            write(w, 1);
            fork
                recv(l9, g);
                begin
                    repeat (20) @(negedge clk);
                    len9 = ~l9; par_en = ~pe; par_odd = ~od;
                end
            join
            frame_check(g, w, l9, pe, od, "R9 random");
        end
        finish_run();
    end
endmodule